// File: doc/BRIEF.md
# NUMA Interleave Request Router

The router sits below the last-level cache of one node in a two-node shared-memory system. It takes cache-miss reads, each naming one 64-byte line, and decides from the line address whether the line lives on this node or on the other one. Three interleave schemes are supported: alternation every 512 bytes, assignment in 1 GB chunks, and a split scheme that uses the first below a programmable boundary and the second at or above it.

A line homed locally goes to one of two memory controllers. Each controller has two channels, and each channel supplies one 32-byte half of the line. The router sends the same address and tag to both channels of the chosen controller. It holds whichever half returns first in a per-tag buffer and emits one 512-bit response once the partner half arrives. A line homed remotely goes out on the inter-node link request port, and the full line that comes back on the link response port is forwarded unchanged.

Every port uses a valid/ready handshake. Each request carries a 4-bit tag that its response echoes, and responses may complete out of order. The interleave configuration is sampled only while no request is outstanding.

Top module: `numa_router`

## Requirements
- R1: After reset no request or response valid is asserted, and `req_ready_o` is high.
- R2: Mode encoding is 2'b00 = 512-byte interleave, 2'b01 = 1 GB interleave, 2'b10 = split, and 2'b11 behaves as 2'b00. In 512-byte interleave the home node is address bit 9.
- R3: In 1 GB interleave the home node is address bit 30.
- R4: In split mode an address strictly below the boundary uses bit 9, and an address equal to or above the boundary uses bit 30.
- R5: A line is local when its home bit equals the NODE_ID parameter (default 0). A local line goes to controller `addr[8]`, so banks 0-3 map to controller 0 and banks 4-7 map to controller 1.
- R6: A local line raises exactly one handshake on each channel port of its controller, and on no other port. The channel port index is controller*2 + channel. Both handshakes carry the request address and tag.
- R7: A remote line raises exactly one link request handshake carrying its address and tag, and no channel handshake. The link response is forwarded with its tag and all 512 data bits unchanged.
- R8: A local response carries channel 0 data in bits [255:0] and channel 1 data in bits [511:256], whichever half arrives first. Each tag produces exactly one response.
- R9: At most 16 tags are outstanding. `req_ready_o` is low while all 16 tags are busy and rises again once a response completes.
- R10: A stalled output port keeps its valid, address or data, and tag stable until the handshake completes. A stall causes no lost and no repeated transfer.
- R11: A change of mode or boundary made while requests are outstanding does not affect routing until the outstanding count has reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 2 | Interleave mode |
| cfg_bound_i | input | AW | Split-mode boundary address |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Miss request accepted |
| req_addr_i | input | AW | Line byte address |
| req_tag_i | input | TW | Request tag |
| ch_req_valid_o | output | 4 | Per-channel request valid (index controller*2+channel) |
| ch_req_ready_i | input | 4 | Per-channel request ready |
| ch_req_addr_o | output | AW | Channel request address |
| ch_req_tag_o | output | TW | Channel request tag |
| ch_rsp_valid_i | input | 4 | Per-channel half response valid |
| ch_rsp_ready_o | output | 4 | Per-channel half response ready |
| ch_rsp_tag_i | input | 4xTW | Per-channel response tag |
| ch_rsp_data_i | input | 4xHW | Per-channel 32-byte half |
| link_req_valid_o | output | 1 | Link request valid |
| link_req_ready_i | input | 1 | Link request ready |
| link_req_addr_o | output | AW | Link request address |
| link_req_tag_o | output | TW | Link request tag |
| link_rsp_valid_i | input | 1 | Link fill valid |
| link_rsp_ready_o | output | 1 | Link fill ready |
| link_rsp_tag_i | input | TW | Link fill tag |
| link_rsp_data_i | input | 2xHW | Link fill line |
| rsp_valid_o | output | 1 | Line response valid |
| rsp_ready_i | input | 1 | Line response ready |
| rsp_tag_o | output | TW | Line response tag |
| rsp_data_o | output | 2xHW | Line response data |

## Verification
Routing is tried with addresses chosen so that bit 9 and bit 30 disagree, which separates one interleave scheme from another. Addresses on and just below the split boundary expose an off-by-one in the compare, and flipping bit 8 tells the two controllers apart. Channel halves are returned both low-first and high-first to catch swapped or lost halves. Separately, a run of sixteen unanswered requests, a reconfiguration issued under load, and stalls on the request and response ports exercise the tag limit, the idle-only configuration update and handshake stability. Random addresses, modes, boundaries and half orders then sweep the combinations.

// File: rtl/numa_pkg.sv
package numa_pkg;
  typedef enum logic [1:0] {
    MODE_FINE   = 2'b00,
    MODE_COARSE = 2'b01,
    MODE_SPLIT  = 2'b10,
    MODE_RSVD   = 2'b11
  } ilv_mode_e;

  localparam int FINE_BIT   = 9;
  localparam int COARSE_BIT = 30;
  localparam int CTRL_BIT   = 8;
  localparam int NCTRL      = 2;
  localparam int NCHAN      = 2;
  localparam int NPORT      = NCTRL * NCHAN;
endpackage

// File: rtl/numa_home_sel.sv
module numa_home_sel #(
  parameter int AW      = 40,
  parameter int NODE_ID = 0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] bound_i,
  output logic          remote_o,
  output logic          ctrl_o
);
  import numa_pkg::*;

  logic home;

  always_comb begin
    unique case (ilv_mode_e'(mode_i))
      MODE_COARSE: home = addr_i[COARSE_BIT];
      MODE_SPLIT:  home = (addr_i < bound_i) ? addr_i[FINE_BIT] : addr_i[COARSE_BIT];
      default:     home = addr_i[FINE_BIT];
    endcase
  end

  assign remote_o = home != NODE_ID[0];
  assign ctrl_o   = addr_i[CTRL_BIT];
endmodule

// File: rtl/numa_dispatch.sv
module numa_dispatch #(
  parameter int AW = 40,
  parameter int TW = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [AW-1:0]               req_addr_i,
  input  logic [TW-1:0]               req_tag_i,
  input  logic                        remote_i,
  input  logic                        ctrl_i,
  input  logic                        done_i,
  input  logic [TW-1:0]               done_tag_i,
  output logic                        idle_o,
  output logic [numa_pkg::NPORT-1:0]  ch_req_valid_o,
  input  logic [numa_pkg::NPORT-1:0]  ch_req_ready_i,
  output logic [AW-1:0]               ch_req_addr_o,
  output logic [TW-1:0]               ch_req_tag_o,
  output logic                        link_req_valid_o,
  input  logic                        link_req_ready_i,
  output logic [AW-1:0]               link_req_addr_o,
  output logic [TW-1:0]               link_req_tag_o
);
  import numa_pkg::*;
  localparam int NT = 1 << TW;

  logic              stg_valid_q, stg_remote_q, stg_ctrl_q;
  logic [AW-1:0]     stg_addr_q;
  logic [TW-1:0]     stg_tag_q;
  logic [NCHAN-1:0]  pend_q, sent, pend_nxt;
  logic [NPORT-1:0]  fire;
  logic [NT-1:0]     busy_q, busy_d;
  logic              acc, link_fire, stg_done;

  assign req_ready_o = !stg_valid_q && !(&busy_q);
  assign acc         = req_valid_i && req_ready_o;
  assign idle_o      = busy_q == '0;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign ch_req_valid_o[p] = stg_valid_q && !stg_remote_q &&
                               (stg_ctrl_q == 1'(p / NCHAN)) && pend_q[p % NCHAN];
    assign fire[p] = ch_req_valid_o[p] && ch_req_ready_i[p];
  end

  always_comb begin
    sent = '0;
    for (int p = 0; p < NPORT; p++)
      if (fire[p]) sent[p % NCHAN] = 1'b1;
  end

  assign pend_nxt  = pend_q & ~sent;
  assign link_fire = link_req_valid_o && link_req_ready_i;
  assign stg_done  = stg_remote_q ? link_fire : (pend_nxt == '0);

  assign ch_req_addr_o    = stg_addr_q;
  assign ch_req_tag_o     = stg_tag_q;
  assign link_req_valid_o = stg_valid_q && stg_remote_q;
  assign link_req_addr_o  = stg_addr_q;
  assign link_req_tag_o   = stg_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_valid_q  <= 1'b0;
      stg_remote_q <= 1'b0;
      stg_ctrl_q   <= 1'b0;
      stg_addr_q   <= '0;
      stg_tag_q    <= '0;
      pend_q       <= '0;
    end else if (acc) begin
      stg_valid_q  <= 1'b1;
      stg_remote_q <= remote_i;
      stg_ctrl_q   <= ctrl_i;
      stg_addr_q   <= req_addr_i;
      stg_tag_q    <= req_tag_i;
      pend_q       <= '1;
    end else if (stg_valid_q) begin
      pend_q <= pend_nxt;
      if (stg_done) stg_valid_q <= 1'b0;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (done_i) busy_d[done_tag_i] = 1'b0;
    if (acc)    busy_d[req_tag_i]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end
endmodule

// File: rtl/numa_merge.sv
module numa_merge #(
  parameter int TW = 4,
  parameter int HW = 256
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [numa_pkg::NPORT-1:0]           ch_rsp_valid_i,
  output logic [numa_pkg::NPORT-1:0]           ch_rsp_ready_o,
  input  logic [numa_pkg::NPORT-1:0][TW-1:0]   ch_rsp_tag_i,
  input  logic [numa_pkg::NPORT-1:0][HW-1:0]   ch_rsp_data_i,
  input  logic                                 link_rsp_valid_i,
  output logic                                 link_rsp_ready_o,
  input  logic [TW-1:0]                        link_rsp_tag_i,
  input  logic [2*HW-1:0]                      link_rsp_data_i,
  output logic                                 rsp_valid_o,
  input  logic                                 rsp_ready_i,
  output logic [TW-1:0]                        rsp_tag_o,
  output logic [2*HW-1:0]                      rsp_data_o,
  output logic                                 done_o
);
  import numa_pkg::*;
  localparam int NT = 1 << TW;
  localparam int LW = 2 * HW;

  logic [HW-1:0]    half_q [NT];
  logic [NT-1:0]    lo_got_q, hi_got_q;
  logic             out_valid_q;
  logic [TW-1:0]    out_tag_q;
  logic [LW-1:0]    out_data_q;
  logic             out_free, found, sel_hi, sel_pair, ch_take;
  logic [TW-1:0]    sel_tag;
  logic [HW-1:0]    sel_data;
  logic [LW-1:0]    pair_line;

  assign out_free = !out_valid_q || rsp_ready_i;

  // one source per cycle, channels ahead of the link
  always_comb begin
    ch_rsp_ready_o   = '0;
    link_rsp_ready_o = 1'b0;
    found    = 1'b0;
    sel_hi   = 1'b0;
    sel_pair = 1'b0;
    sel_tag  = '0;
    sel_data = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic partner;
      partner = (p % NCHAN == 0) ? hi_got_q[ch_rsp_tag_i[p]] : lo_got_q[ch_rsp_tag_i[p]];
      if (!found && ch_rsp_valid_i[p] && (!partner || out_free)) begin
        found             = 1'b1;
        ch_rsp_ready_o[p] = 1'b1;
        sel_hi            = (p % NCHAN) != 0;
        sel_pair          = partner;
        sel_tag           = ch_rsp_tag_i[p];
        sel_data          = ch_rsp_data_i[p];
      end
    end
    if (!found && link_rsp_valid_i && out_free) link_rsp_ready_o = 1'b1;
  end

  assign ch_take   = found;
  assign pair_line = sel_hi ? {sel_data, half_q[sel_tag]} : {half_q[sel_tag], sel_data};

  always_ff @(posedge clk_i) begin
    if (ch_take && !sel_pair) half_q[sel_tag] <= sel_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_got_q    <= '0;
      hi_got_q    <= '0;
      out_valid_q <= 1'b0;
      out_tag_q   <= '0;
      out_data_q  <= '0;
    end else begin
      if (ch_take && sel_pair) begin
        lo_got_q[sel_tag] <= 1'b0;
        hi_got_q[sel_tag] <= 1'b0;
        out_valid_q <= 1'b1;
        out_tag_q   <= sel_tag;
        out_data_q  <= pair_line;
      end else if (link_rsp_ready_o) begin
        out_valid_q <= 1'b1;
        out_tag_q   <= link_rsp_tag_i;
        out_data_q  <= link_rsp_data_i;
      end else if (rsp_ready_i) begin
        out_valid_q <= 1'b0;
      end
      if (ch_take && !sel_pair) begin
        if (sel_hi) hi_got_q[sel_tag] <= 1'b1;
        else        lo_got_q[sel_tag] <= 1'b1;
      end
    end
  end

  assign rsp_valid_o = out_valid_q;
  assign rsp_tag_o   = out_tag_q;
  assign rsp_data_o  = out_data_q;
  assign done_o      = out_valid_q && rsp_ready_i;
endmodule

// File: rtl/numa_router.sv
module numa_router #(
  parameter int AW      = 40,
  parameter int TW      = 4,
  parameter int HW      = 256,
  parameter int NODE_ID = 0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [1:0]                          cfg_mode_i,
  input  logic [AW-1:0]                       cfg_bound_i,
  input  logic                                req_valid_i,
  output logic                                req_ready_o,
  input  logic [AW-1:0]                       req_addr_i,
  input  logic [TW-1:0]                       req_tag_i,
  output logic [numa_pkg::NPORT-1:0]          ch_req_valid_o,
  input  logic [numa_pkg::NPORT-1:0]          ch_req_ready_i,
  output logic [AW-1:0]                       ch_req_addr_o,
  output logic [TW-1:0]                       ch_req_tag_o,
  input  logic [numa_pkg::NPORT-1:0]          ch_rsp_valid_i,
  output logic [numa_pkg::NPORT-1:0]          ch_rsp_ready_o,
  input  logic [numa_pkg::NPORT-1:0][TW-1:0]  ch_rsp_tag_i,
  input  logic [numa_pkg::NPORT-1:0][HW-1:0]  ch_rsp_data_i,
  output logic                                link_req_valid_o,
  input  logic                                link_req_ready_i,
  output logic [AW-1:0]                       link_req_addr_o,
  output logic [TW-1:0]                       link_req_tag_o,
  input  logic                                link_rsp_valid_i,
  output logic                                link_rsp_ready_o,
  input  logic [TW-1:0]                       link_rsp_tag_i,
  input  logic [2*HW-1:0]                     link_rsp_data_i,
  output logic                                rsp_valid_o,
  input  logic                                rsp_ready_i,
  output logic [TW-1:0]                       rsp_tag_o,
  output logic [2*HW-1:0]                     rsp_data_o
);
  logic [1:0]    mode_q;
  logic [AW-1:0] bound_q;
  logic          remote, ctrl, idle, done;

  // config is only sampled with nothing in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 2'b00;
      bound_q <= '0;
    end else if (idle) begin
      mode_q  <= cfg_mode_i;
      bound_q <= cfg_bound_i;
    end
  end

  numa_home_sel #(.AW(AW), .NODE_ID(NODE_ID)) i_home_sel (
    .addr_i   (req_addr_i),
    .mode_i   (mode_q),
    .bound_i  (bound_q),
    .remote_o (remote),
    .ctrl_o   (ctrl)
  );

  numa_dispatch #(.AW(AW), .TW(TW)) i_dispatch (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_addr_i       (req_addr_i),
    .req_tag_i        (req_tag_i),
    .remote_i         (remote),
    .ctrl_i           (ctrl),
    .done_i           (done),
    .done_tag_i       (rsp_tag_o),
    .idle_o           (idle),
    .ch_req_valid_o   (ch_req_valid_o),
    .ch_req_ready_i   (ch_req_ready_i),
    .ch_req_addr_o    (ch_req_addr_o),
    .ch_req_tag_o     (ch_req_tag_o),
    .link_req_valid_o (link_req_valid_o),
    .link_req_ready_i (link_req_ready_i),
    .link_req_addr_o  (link_req_addr_o),
    .link_req_tag_o   (link_req_tag_o)
  );

  numa_merge #(.TW(TW), .HW(HW)) i_merge (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ch_rsp_valid_i   (ch_rsp_valid_i),
    .ch_rsp_ready_o   (ch_rsp_ready_o),
    .ch_rsp_tag_i     (ch_rsp_tag_i),
    .ch_rsp_data_i    (ch_rsp_data_i),
    .link_rsp_valid_i (link_rsp_valid_i),
    .link_rsp_ready_o (link_rsp_ready_o),
    .link_rsp_tag_i   (link_rsp_tag_i),
    .link_rsp_data_i  (link_rsp_data_i),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_ready_i      (rsp_ready_i),
    .rsp_tag_o        (rsp_tag_o),
    .rsp_data_o       (rsp_data_o),
    .done_o           (done)
  );
endmodule

// File: rtl/numa_router_chk.sv
module numa_router_chk #(
  parameter int AW = 40,
  parameter int TW = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_valid_i,
  input logic                        req_ready_o,
  input logic [numa_pkg::NPORT-1:0]  ch_req_valid_o,
  input logic [numa_pkg::NPORT-1:0]  ch_req_ready_i,
  input logic [AW-1:0]               ch_req_addr_o,
  input logic [TW-1:0]               ch_req_tag_o,
  input logic                        link_req_valid_o,
  input logic                        link_req_ready_i,
  input logic [AW-1:0]               link_req_addr_o,
  input logic                        rsp_valid_o,
  input logic                        rsp_ready_i,
  input logic [TW-1:0]               rsp_tag_o
);
  localparam int NT = 1 << TW;

  logic [TW:0] cnt_q;
  logic        req_hs, rsp_hs;

  assign req_hs = req_valid_i && req_ready_o;
  assign rsp_hs = rsp_valid_o && rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + (TW+1)'(req_hs) - (TW+1)'(rsp_hs);
  end

  // R9
  tag_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (TW+1)'(NT));

  // R9
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == (TW+1)'(NT)) |-> !req_ready_o);

  // R10
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ch_req_valid_o & ~ch_req_ready_i)) |=>
      ((ch_req_valid_o & ~$past(ch_req_ready_i)) == ($past(ch_req_valid_o) & ~$past(ch_req_ready_i)))
      && $stable(ch_req_addr_o) && $stable(ch_req_tag_o));

  // R10
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_valid_o && !link_req_ready_i) |=> link_req_valid_o && $stable(link_req_addr_o));

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_tag_o));

  // R6
  one_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|ch_req_valid_o[3:2], |ch_req_valid_o[1:0]}));

  // R7
  link_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_req_valid_o |-> (ch_req_valid_o == '0));
endmodule

bind numa_router numa_router_chk #(.AW(AW), .TW(TW)) i_numa_router_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .ch_req_valid_o   (ch_req_valid_o),
  .ch_req_ready_i   (ch_req_ready_i),
  .ch_req_addr_o    (ch_req_addr_o),
  .ch_req_tag_o     (ch_req_tag_o),
  .link_req_valid_o (link_req_valid_o),
  .link_req_ready_i (link_req_ready_i),
  .link_req_addr_o  (link_req_addr_o),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_ready_i      (rsp_ready_i),
  .rsp_tag_o        (rsp_tag_o)
);

// File: tb/test_numa_router.sv
module test_numa_router;
  localparam int AW = 40;
  localparam int TW = 4;
  localparam int HW = 256;
  localparam int LW = 2 * HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]           cfg_mode = 2'b00;
  logic [AW-1:0]        cfg_bound = '0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [AW-1:0]        req_addr = '0;
  logic [TW-1:0]        req_tag = '0;
  logic [3:0]           ch_req_valid;
  logic [3:0]           ch_req_ready = 4'hf;
  logic [AW-1:0]        ch_req_addr;
  logic [TW-1:0]        ch_req_tag;
  logic [3:0]           ch_rsp_valid = '0;
  logic [3:0]           ch_rsp_ready;
  logic [3:0][TW-1:0]   ch_rsp_tag = '0;
  logic [3:0][HW-1:0]   ch_rsp_data = '0;
  logic                 link_req_valid;
  logic                 link_req_ready = 1'b1;
  logic [AW-1:0]        link_req_addr;
  logic [TW-1:0]        link_req_tag;
  logic                 link_rsp_valid = 1'b0;
  logic                 link_rsp_ready;
  logic [TW-1:0]        link_rsp_tag = '0;
  logic [LW-1:0]        link_rsp_data = '0;
  logic                 rsp_valid;
  logic                 rsp_ready = 1'b1;
  logic [TW-1:0]        rsp_tag;
  logic [LW-1:0]        rsp_data;

  numa_router #(.AW(AW), .TW(TW), .HW(HW), .NODE_ID(0)) i_numa_router (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_bound_i(cfg_bound),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_tag_i(req_tag),
    .ch_req_valid_o(ch_req_valid), .ch_req_ready_i(ch_req_ready),
    .ch_req_addr_o(ch_req_addr), .ch_req_tag_o(ch_req_tag),
    .ch_rsp_valid_i(ch_rsp_valid), .ch_rsp_ready_o(ch_rsp_ready),
    .ch_rsp_tag_i(ch_rsp_tag), .ch_rsp_data_i(ch_rsp_data),
    .link_req_valid_o(link_req_valid), .link_req_ready_i(link_req_ready),
    .link_req_addr_o(link_req_addr), .link_req_tag_o(link_req_tag),
    .link_rsp_valid_i(link_rsp_valid), .link_rsp_ready_o(link_rsp_ready),
    .link_rsp_tag_i(link_rsp_tag), .link_rsp_data_i(link_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  // model configuration (what the bench applied while idle)
  logic [1:0]    m_mode  = 2'b00;
  logic [AW-1:0] m_bound = '0;

  // port monitors, sampled 1 ns after the falling edge
  int            ch_cnt [4];
  logic [AW-1:0] ch_addr_l [4];
  logic [TW-1:0] ch_tag_l [4];
  int            link_cnt = 0;
  logic [AW-1:0] link_addr_l;
  logic [TW-1:0] link_tag_l;
  int            rsp_cnt = 0;
  logic [TW-1:0] rsp_tag_l;
  logic [LW-1:0] rsp_data_l;

  initial for (int i = 0; i < 4; i++) ch_cnt[i] = 0;

  always @(negedge clk) begin
    #1;
    for (int i = 0; i < 4; i++)
      if (ch_req_valid[i] && ch_req_ready[i]) begin
        ch_cnt[i]++; ch_addr_l[i] = ch_req_addr; ch_tag_l[i] = ch_req_tag;
      end
    if (link_req_valid && link_req_ready) begin
      link_cnt++; link_addr_l = link_req_addr; link_tag_l = link_req_tag;
    end
    if (rsp_valid && rsp_ready) begin
      rsp_cnt++; rsp_tag_l = rsp_tag; rsp_data_l = rsp_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_remote(input logic [AW-1:0] a, input logic [1:0] m, input logic [AW-1:0] b);
    logic h;
    case (m)
      2'b01:   h = a[30];
      2'b10:   h = (a < b) ? a[9] : a[30];
      default: h = a[9];
    endcase
    return h != 1'b0;
  endfunction

  function automatic logic [LW-1:0] rnd_line();
    logic [LW-1:0] v;
    for (int i = 0; i < LW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [AW-1:0] b);
    @(negedge clk);
    cfg_mode = m; cfg_bound = b;
    m_mode = m; m_bound = b;
    wait_cyc(2);
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [TW-1:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tag = t;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drive_ch(input int p, input logic [TW-1:0] t, input logic [HW-1:0] d);
    @(negedge clk);
    ch_rsp_valid[p] = 1'b1; ch_rsp_tag[p] = t; ch_rsp_data[p] = d;
    #1;
    while (!ch_rsp_ready[p]) begin @(negedge clk); #1; end
    @(negedge clk);
    ch_rsp_valid[p] = 1'b0;
  endtask

  task automatic drive_link(input logic [TW-1:0] t, input logic [LW-1:0] d);
    @(negedge clk);
    link_rsp_valid = 1'b1; link_rsp_tag = t; link_rsp_data = d;
    #1;
    while (!link_rsp_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    link_rsp_valid = 1'b0;
  endtask

  // issue a line and check where it went
  task automatic route(input logic [AW-1:0] a, input logic [TW-1:0] t, input bit exp_rem, input string req);
    int c0 [4];
    int l0;
    bit ok;
    int ctl;
    for (int i = 0; i < 4; i++) c0[i] = ch_cnt[i];
    l0 = link_cnt;
    issue(a, t);
    wait_cyc(4);
    ctl = a[8] ? 1 : 0;
    ok = 1'b1;
    if (exp_rem) begin
      ok = (link_cnt == l0 + 1) && (link_addr_l == a) && (link_tag_l == t);
      for (int i = 0; i < 4; i++) if (ch_cnt[i] != c0[i]) ok = 1'b0;
    end else begin
      if (link_cnt != l0) ok = 1'b0;
      for (int i = 0; i < 4; i++) begin
        int e;
        e = (i / 2 == ctl) ? 1 : 0;
        if (ch_cnt[i] != c0[i] + e) ok = 1'b0;
        if (e == 1 && (ch_addr_l[i] != a || ch_tag_l[i] != t)) ok = 1'b0;
      end
    end
    chk(ok, req, LW'({link_cnt - l0, ch_cnt[0] - c0[0], ch_cnt[1] - c0[1], ch_cnt[2] - c0[2], ch_cnt[3] - c0[3]}),
        LW'({exp_rem, a}));
  endtask

  task automatic answer(input logic [AW-1:0] a, input logic [TW-1:0] t, input bit rem, input bit hi_first, input string req);
    logic [LW-1:0] line;
    int r0;
    int p0;
    line = rnd_line();
    r0 = rsp_cnt;
    p0 = a[8] ? 2 : 0;
    if (rem) drive_link(t, line);
    else if (hi_first) begin drive_ch(p0 + 1, t, line[LW-1:HW]); drive_ch(p0, t, line[HW-1:0]); end
    else begin drive_ch(p0, t, line[HW-1:0]); drive_ch(p0 + 1, t, line[LW-1:HW]); end
    wait_cyc(4);
    chk(rsp_cnt == r0 + 1 && rsp_tag_l == t && rsp_data_l == line, req, rsp_data_l, line);
  endtask

  task automatic full_txn(input logic [AW-1:0] a, input logic [TW-1:0] t, input string req);
    bit rem;
    rem = f_remote(a, m_mode, m_bound);
    route(a, t, rem, req);
    answer(a, t, rem, $urandom_range(1, 0) == 1, req);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c_before;
    int r_before;
    void'($urandom(32'h5eed_1234));
    wait_cyc(3);
    #1;
    // R1
    chk(req_ready == 1'b0 || (ch_req_valid == 0 && !link_req_valid && !rsp_valid), "R1 in reset", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(1);
    #1;
    chk(req_ready && ch_req_valid == 0 && !link_req_valid && !rsp_valid, "R1",
        LW'({req_ready, ch_req_valid, link_req_valid, rsp_valid}), LW'(7'b1000000));

    // R2 / R5: 512-byte interleave
    set_cfg(2'b00, '0);
    route(40'h0000_1000, 4'd1, 1'b0, "R2 bit9=0 local ctrl0");
    answer(40'h0000_1000, 4'd1, 1'b0, 1'b0, "R8 low-first");
    route(40'h0000_1100, 4'd2, 1'b0, "R5 bit8 picks ctrl1");
    answer(40'h0000_1100, 4'd2, 1'b0, 1'b1, "R8 high-first");
    route(40'h4000_1200, 4'd3, 1'b1, "R2 bit9=1 remote");
    answer(40'h4000_1200, 4'd3, 1'b1, 1'b0, "R7 link fill");
    set_cfg(2'b11, '0);
    route(40'h0000_0200, 4'd4, 1'b1, "R2 mode 3 acts as fine");
    answer(40'h0000_0200, 4'd4, 1'b1, 1'b0, "R7");

    // R3: 1 GB interleave
    set_cfg(2'b01, '0);
    route(40'h4000_0000, 4'd5, 1'b1, "R3 bit30=1 remote");
    answer(40'h4000_0000, 4'd5, 1'b1, 1'b0, "R7");
    route(40'h0000_0300, 4'd6, 1'b0, "R3 bit9 ignored");
    answer(40'h0000_0300, 4'd6, 1'b0, 1'b1, "R8");

    // R4: split at 0x6000_0000
    set_cfg(2'b10, 40'h6000_0000);
    route(40'h6000_0000, 4'd7, 1'b1, "R4 at boundary uses bit30");
    answer(40'h6000_0000, 4'd7, 1'b1, 1'b0, "R7");
    route(40'h5fff_fdc0, 4'd8, 1'b0, "R4 below boundary uses bit9");
    answer(40'h5fff_fdc0, 4'd8, 1'b0, 1'b0, "R8");
    route(40'h1000_0200, 4'd9, 1'b1, "R4 low region bit9=1");
    answer(40'h1000_0200, 4'd9, 1'b1, 1'b0, "R7");

    // R10: stalled channel request port
    set_cfg(2'b00, '0);
    @(negedge clk);
    ch_req_ready = 4'b1101;
    c_before = ch_cnt[1];
    issue(40'h0000_0040, 4'd10);
    wait_cyc(5);
    #1;
    chk(ch_req_valid[1] && ch_cnt[1] == c_before && ch_req_addr == 40'h0000_0040, "R10 request held",
        LW'({ch_req_valid, ch_req_addr}), LW'({4'b0010, 40'h0000_0040}));
    @(negedge clk);
    ch_req_ready = 4'hf;
    wait_cyc(5);
    chk(ch_cnt[1] == c_before + 1 && ch_cnt[0] == c_before + 1 - (ch_cnt[1] - ch_cnt[0]),
        "R10 request sent once", LW'(ch_cnt[1] - c_before), LW'(1));
    // R10: stalled response port
    @(negedge clk);
    rsp_ready = 1'b0;
    r_before = rsp_cnt;
    drive_ch(0, 4'd10, {HW/32{32'haaaa_5555}});
    drive_ch(1, 4'd10, {HW/32{32'h1234_abcd}});
    wait_cyc(4);
    #1;
    chk(rsp_valid && rsp_tag == 4'd10 && rsp_cnt == r_before, "R10 response held",
        LW'({rsp_valid, rsp_tag}), LW'({1'b1, 4'd10}));
    @(negedge clk);
    rsp_ready = 1'b1;
    wait_cyc(5);
    chk(rsp_cnt == r_before + 1 && rsp_data_l == {{HW/32{32'h1234_abcd}}, {HW/32{32'haaaa_5555}}},
        "R10 R8 response once", rsp_data_l, {{HW/32{32'h1234_abcd}}, {HW/32{32'haaaa_5555}}});

    // R9: sixteen outstanding tags
    for (int t = 0; t < 16; t++) issue(40'(t) << 6, 4'(t));
    wait_cyc(3);
    #1;
    chk(!req_ready, "R9 ready low when all tags busy", LW'(req_ready), '0);
    r_before = rsp_cnt;
    drive_ch(0, 4'd0, '0);
    drive_ch(1, 4'd0, '1);
    wait_cyc(3);
    #1;
    chk(req_ready && rsp_cnt == r_before + 1, "R9 ready back after a response",
        LW'({req_ready, rsp_cnt - r_before}), LW'({1'b1, 32'd1}));
    for (int t = 1; t < 16; t++) begin
      int p0;
      p0 = (t & 4) != 0 ? 2 : 0;
      drive_ch(p0 + 1, 4'(t), HW'(t));
      drive_ch(p0, 4'(t), HW'(t + 100));
    end
    wait_cyc(4);
    chk(rsp_cnt == r_before + 16, "R8 one response per tag", LW'(rsp_cnt - r_before), LW'(16));

    // R11: config change while busy is deferred
    set_cfg(2'b00, '0);
    issue(40'h0000_0000, 4'd11);
    wait_cyc(2);
    @(negedge clk);
    cfg_mode = 2'b01;
    wait_cyc(2);
    route(40'h4000_0040, 4'd12, 1'b0, "R11 old mode still in force");
    answer(40'h4000_0040, 4'd12, 1'b0, 1'b0, "R11");
    answer(40'h0000_0000, 4'd11, 1'b0, 1'b1, "R11");
    m_mode = 2'b01;
    wait_cyc(3);
    route(40'h4000_0040, 4'd13, 1'b1, "R11 new mode after idle");
    answer(40'h4000_0040, 4'd13, 1'b1, 1'b0, "R11");

    // random sweep over R2-R8
    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] a;
      if (i % 8 == 0) set_cfg(2'($urandom_range(3, 0)), AW'($urandom));
      a = AW'($urandom) & ~AW'(63);
      full_txn(a, 4'($urandom_range(15, 0)), "R6 R7 R8 random");
    end

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule